// File: doc/BRIEF.md
# Rewritable Multipartite Function Lookup Unit

This unit evaluates a fixed-point function of a 32-bit operand with four small tables in place of one enormous one. The low 31 operand bits are cut into a 12-bit leading field and three trailing fields. A base table is addressed by the leading field. Each of three correction tables is addressed by a few of the operand's top bits joined to its own trailing field. All four tables are read in the same cycle, and a two-level adder tree sums the four words into the result.

The table contents set which function the unit computes, so a new function can be loaded whenever the running program changes. Loading goes through a narrow configuration port that models a slow nonvolatile write. Each accepted word keeps a busy flag raised for a programmable number of cycles. While that flag is up, the lookup side refuses operands and further writes are dropped. Lookups stream at one per cycle with a fixed latency.

Top module: `mpl_lookup_unit`

## Requirements
- R1: The field bits are operand bits 30..0, and bit 31 has no effect on the result. The leading field is bits 30..19. Trailing field one is bits 18..14, field two is bits 13..8 and field three is bits 7..0.
- R2: Table 0 (base) is addressed by the 12-bit leading field alone.
- R3: Correction table k (k = 1, 2, 3) is addressed by {top g_k operand bits counted down from bit 30, trailing field k}, with g = 7, 6 and 4, so every address is 12 bits wide.
- R4: The result is the two's-complement sum of the four 32-bit table words, wrapping modulo 2^32.
- R5: A lookup is accepted on a rising edge where in_valid and in_ready are both high. Its result appears with out_valid after the second following rising edge (three-cycle latency). Back-to-back lookups give one result per cycle.
- R6: A write is accepted on a rising edge where cfg_we is high and cfg_busy is low. It stores cfg_data at cfg_addr of the table named by cfg_sel (0 is base, 1 to 3 are the correction tables). cfg_busy is then high for exactly WR_LAT cycles.
- R7: While cfg_busy is high, in_ready is low, no lookup is accepted, and cfg_we is ignored: the table is unchanged and the busy period is not extended.
- R8: A lookup accepted on the same edge as a write, or earlier, reads the contents from before that write.
- R9: After reset every table entry reads as zero, cfg_busy and out_valid are low, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand |
| in_operand | input | 32 | Function argument |
| out_valid | output | 1 | Result valid this cycle |
| out_result | output | 32 | Function value |
| cfg_we | input | 1 | Table write request |
| cfg_sel | input | 2 | Table number for the write |
| cfg_addr | input | 12 | Entry address for the write |
| cfg_data | input | 32 | Entry value |
| cfg_busy | output | 1 | Slow write in progress |

## Verification
The bench keeps the default field split and 32-bit words, so the address formation of all four tables is checked exactly as built. It lowers WR_LAT to 9 cycles. The busy window is then short enough for thousands of mixed writes and lookups, which often collide with writes on the same edge or arrive during the blocked period. Operands are mostly drawn from a small pool, and table writes land on addresses those operands reach. Most lookups therefore sum several nonzero, often wrapping, words.

// File: rtl/mpl_pkg.sv
package mpl_pkg;
  localparam int unsigned NUM_TABLES = 4;
  localparam int unsigned SEL_W      = 2;
  typedef logic [SEL_W-1:0] tsel_t;
endpackage

// File: rtl/mpl_table.sv
module mpl_table #(
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_q
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  filled_q;
  logic [DATA_W-1:0] rd_d;

  // storage array carries no reset; a per-entry flag makes untouched words read zero
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filled_q <= '0;
    else if (wr_en) filled_q[wr_idx] <= 1'b1;
  end

  always_comb begin
    rd_d = filled_q[rd_idx] ? mem[rd_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  // R9: an entry never written reads back as zero
  a_r9_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !filled_q[rd_idx]) |=> (rd_q == '0));
endmodule

// File: rtl/mpl_write_timer.sv
module mpl_write_timer #(
  parameter int unsigned WR_LAT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic accept,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(WR_LAT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy   = (cnt_q != '0);
    accept = req && !busy;
    cnt_d  = cnt_q;
    if (accept)    cnt_d = CNT_W'(WR_LAT);
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r6_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WR_LAT));
endmodule

// File: rtl/mpl_adder_tree.sv
module mpl_adder_tree
  import mpl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] tab_q [NUM_TABLES],
  output logic              out_vld,
  output logic [DATA_W-1:0] out_sum
);
  logic              pair_vld_q;
  logic [DATA_W-1:0] sum01_q, sum23_q, sum01_d, sum23_d, total_d;

  always_comb begin
    sum01_d = tab_q[0] + tab_q[1];
    sum23_d = tab_q[2] + tab_q[3];
    total_d = sum01_q + sum23_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_vld_q <= 1'b0;
      sum01_q    <= '0;
      sum23_q    <= '0;
    end else begin
      pair_vld_q <= in_vld;
      if (in_vld) begin
        sum01_q <= sum01_d;
        sum23_q <= sum23_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_sum <= '0;
    end else begin
      out_vld <= pair_vld_q;
      if (pair_vld_q) out_sum <= total_d;
    end
  end

  a_r5_first_level: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> pair_vld_q);
  a_r5_second_level: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_q |=> out_vld);
  a_r4_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_vld_q |=> $stable(out_sum));
endmodule

// File: rtl/mpl_lookup_unit.sv
module mpl_lookup_unit
  import mpl_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ALPHA_W = 12,
  parameter int unsigned B1_W    = 5,
  parameter int unsigned B2_W    = 6,
  parameter int unsigned B3_W    = 8,
  parameter int unsigned G1_W    = 7,
  parameter int unsigned G2_W    = 6,
  parameter int unsigned G3_W    = 4,
  parameter int unsigned WR_LAT  = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_operand,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_result,
  input  logic                  cfg_we,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  logic [ALPHA_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]     cfg_data,
  output logic                  cfg_busy
);
  localparam int unsigned IDX_W  = ALPHA_W;
  localparam int unsigned FLD_W  = ALPHA_W + B1_W + B2_W + B3_W;
  localparam int unsigned B1_LSB = B2_W + B3_W;
  localparam int unsigned B2_LSB = B3_W;

  logic             fire, rd_vld_q, wr_accept;
  logic [FLD_W-1:0] fld;
  logic             unused_msb;
  logic [IDX_W-1:0] idx   [NUM_TABLES];
  logic [DATA_W-1:0] tab_q [NUM_TABLES];

  assign unused_msb = in_operand[DATA_W-1];

  always_comb begin
    in_ready = !cfg_busy;
    fire     = in_valid && in_ready;
    fld      = in_operand[FLD_W-1:0];
    idx[0]   = fld[FLD_W-1 -: ALPHA_W];
    idx[1]   = {fld[FLD_W-1 -: G1_W], fld[B1_LSB +: B1_W]};
    idx[2]   = {fld[FLD_W-1 -: G2_W], fld[B2_LSB +: B2_W]};
    idx[3]   = {fld[FLD_W-1 -: G3_W], fld[0 +: B3_W]};
  end

  mpl_write_timer #(.WR_LAT(WR_LAT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (cfg_we),
    .accept (wr_accept),
    .busy   (cfg_busy)
  );

  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_tab
    mpl_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (fire),
      .rd_idx  (idx[g]),
      .wr_en   (wr_accept && (cfg_sel == tsel_t'(g))),
      .wr_idx  (cfg_addr),
      .wr_data (cfg_data),
      .rd_q    (tab_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= fire;
  end

  mpl_adder_tree #(.DATA_W(DATA_W)) u_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (rd_vld_q),
    .tab_q   (tab_q),
    .out_vld (out_valid),
    .out_sum (out_result)
  );

  a_r5_accept_reads: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rd_vld_q);
  a_r7_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && in_valid) |=> !rd_vld_q);
  a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busy && cfg_we) |=> cfg_busy || $past(u_timer.cnt_q == 1));
endmodule

// File: tb/test_mpl_lookup_unit.sv
module test_mpl_lookup_unit;
  localparam int WR_LAT = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        cfg_busy;

  always #4 clk = ~clk;

  mpl_lookup_unit #(.WR_LAT(WR_LAT)) i_mpl_lookup_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .out_valid(out_valid), .out_result(out_result),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_busy(cfg_busy)
  );

  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;
  string       cur_tag = "R9";
  logic [31:0] ref_t [4][4096];
  bit          m_v [3];
  logic [31:0] m_d [3];
  int          b_cnt = 0;
  logic [31:0] pool [16];

  function automatic logic [11:0] bidx(int s, logic [31:0] op);
    case (s)
      0: return op[30:19];
      1: return {op[30:24], op[18:14]};
      2: return {op[30:25], op[13:8]};
      default: return {op[30:27], op[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] ref_sum(logic [31:0] op);
    logic [31:0] s = '0;
    for (int k = 0; k < 4; k++) s = s + ref_t[k][bidx(k, op)];
    return s;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit iv, logic [31:0] op, bit we, int sel, logic [11:0] addr,
                      logic [31:0] data);
    bit          acc;
    logic [31:0] e;
    @(negedge clk);
    chk(out_valid == m_v[2], "R5", 32'(out_valid), 32'(m_v[2]));
    if (m_v[2]) chk(out_result == m_d[2], cur_tag, out_result, m_d[2]);
    chk(cfg_busy == (b_cnt != 0), "R6", 32'(cfg_busy), 32'(b_cnt != 0));
    chk(in_ready == (b_cnt == 0), "R7", 32'(in_ready), 32'(b_cnt == 0));
    in_valid = iv; in_operand = op;
    cfg_we = we; cfg_sel = 2'(sel); cfg_addr = addr; cfg_data = data;
    acc = iv && (b_cnt == 0);
    e = ref_sum(op);            // R8: read before the write of this edge
    if (we && b_cnt == 0) begin
      ref_t[sel][addr] = data;
      b_cnt = WR_LAT;
    end else if (b_cnt > 0) begin
      b_cnt--;
    end
    m_v[2] = m_v[1]; m_d[2] = m_d[1];
    m_v[1] = m_v[0]; m_d[1] = m_d[0];
    m_v[0] = acc;    m_d[0] = e;
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0, '0);
  endtask

  task automatic drain();
    while (b_cnt != 0) idle();
    repeat (3) idle();
  endtask

  task automatic wr(int sel, logic [31:0] op, logic [31:0] data);
    step(0, '0, 1, sel, bidx(sel, op), data);
  endtask

  initial begin
    logic [31:0] opa, opb, opc, opd, ope;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 4096; a++) ref_t[k][a] = '0;
    for (int k = 0; k < 3; k++) begin m_v[k] = 0; m_d[k] = '0; end
    for (int k = 0; k < 16; k++) pool[k] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state at the ports
    chk(out_valid == 1'b0, "R9", 32'(out_valid), 0);
    chk(cfg_busy == 1'b0, "R9", 32'(cfg_busy), 0);
    chk(in_ready == 1'b1, "R9", 32'(in_ready), 1);

    cur_tag = "R9";
    for (int k = 0; k < 6; k++) step(1, $urandom, 0, 0, '0, '0);
    drain();

    cur_tag = "R2";
    opa = 32'h5A3C_96E1;
    wr(0, opa, 32'h1234_5678); drain();
    step(1, opa, 0, 0, '0, '0); drain();

    cur_tag = "R1";
    step(1, opa ^ 32'h8000_0000, 0, 0, '0, '0); drain();

    cur_tag = "R3";
    wr(1, opa, 32'h0000_1000); drain();
    wr(2, opa, 32'h0020_0000); drain();
    wr(3, opa, 32'h0000_0003); drain();
    opb = opa ^ 32'h0000_4000;  // differs in trailing field one only
    step(1, opa, 0, 0, '0, '0);
    step(1, opb, 0, 0, '0, '0);
    step(1, opa ^ 32'h0000_0100, 0, 0, '0, '0);
    step(1, opa ^ 32'h0000_0001, 0, 0, '0, '0);
    drain();

    cur_tag = "R4";
    opc = 32'h0123_4567;
    wr(0, opc, 32'hFFFF_FFFF); drain();
    wr(3, opc, 32'h0000_0002); drain();
    step(1, opc, 0, 0, '0, '0); drain();

    cur_tag = "R7";
    opd = 32'h7777_0F0F;
    wr(2, opd, 32'd5);
    step(1, opd, 1, 2, bidx(2, opd), 32'd99);
    step(1, opd, 1, 0, bidx(0, opd), 32'd77);
    drain();
    step(1, opd, 0, 0, '0, '0); drain();

    cur_tag = "R8";
    ope = 32'h2468_ACE0;
    step(1, ope, 1, 0, bidx(0, ope), 32'd7);
    drain();
    step(1, ope, 0, 0, '0, '0); drain();

    cur_tag = "R5";
    for (int k = 0; k < 8; k++) step(1, pool[k], 0, 0, '0, '0);
    drain();

    cur_tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] op, wop;
      int          s;
      op  = ($urandom % 5 == 0) ? $urandom : pool[$urandom % 16];
      wop = pool[$urandom % 16];
      s   = $urandom % 4;
      step(($urandom % 10) < 7, op, ($urandom % 20) == 0, s, bidx(s, wop), $urandom);
    end
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule